// File: doc/BRIEF.md
# Interrupt entry sequencer

This block carries a processor from normal execution into an interrupt handler once an external interrupt with a vector number is accepted. A request is taken only while the interrupt-enable input is set. When a request is accepted, the block snapshots the register state that it needs. It pulses a user-mode clear strobe. One cycle later it writes the context registers in a single cycle:

- the transformed status word;
- the return address (the current PC);
- the exception status (the vector number times 256);
- a zero exception data address;
- when the processor was in user mode, the stack swap.

In that same cycle it starts a word read of the vector table. When the read returns, the fetched word becomes the new PC. When the read returns an error, the entry ends with a fault pulse and the PC is left alone.

The surrounding core owns the registers. It applies the write strobes in the cycle they are high. It holds off new requests while the ready output is low. The memory side is a request held high until a one-cycle acknowledge or error response.

Top module: `irq_entry_seq`

## Requirements
- R1: A request seen while the interrupt-enable input is low is dropped. No strobe, read request, done or fault appears, and ready stays high.
- R2: The written status equals ((old << 10) & 0x3FFFFFFF) | (old & 0x80000000), using the status sampled at acceptance.
- R3: The user-mode clear strobe is high for one cycle. The context write strobe follows in the next cycle, and the context write never comes without that preceding clear.
- R4: When the user-mode input was high at acceptance, the stack strobe writes the old SP to the user stack register and loads SP from the kernel stack pointer, in the context write cycle. In kernel mode the stack strobe stays low.
- R5: In the context write cycle, the return register receives the sampled PC, exception status receives vector << 8 (zero-extended), and the exception data address receives 0.
- R6: The read address is base + vector*4. It is presented from the context write cycle until the response. Byte lane k of the read data (bits 8k+7:8k) is the byte at address+k, so the new PC has the lowest-addressed byte in bits 7:0.
- R7: An error response ends the entry with a one-cycle fault pulse. It causes no PC write and no done pulse.
- R8: Ready is high in idle after reset, low from acceptance until the entry completes, and requests arriving while it is low are held off until it returns high.
- R9: Each accepted request yields exactly one done or fault pulse, one cycle wide, in the cycle after the response is sampled. A successful entry raises the PC write strobe together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interrupt request present |
| req_vector | input | 8 | Interrupt vector number |
| req_ready | output | 1 | Sequencer idle and able to accept |
| int_en | input | 1 | Interrupt-enable bit |
| user_mode | input | 1 | Processor currently in user mode |
| status_in | input | 32 | Current status word |
| pc_in | input | 32 | Current PC |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| vbase_in | input | 32 | Vector table base address |
| umode_clr | output | 1 | Clear the user-mode bit |
| ctx_we | output | 1 | Write status, return, exception status and data address |
| status_out | output | 32 | New status word |
| ret_out | output | 32 | Return address |
| exs_out | output | 32 | Exception status value |
| eda_out | output | 32 | Exception data address value |
| stk_we | output | 1 | Write user stack register and SP |
| usp_out | output | 32 | Value for the user stack register |
| sp_out | output | 32 | Value for SP |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_ack | input | 1 | Read data valid |
| rd_err | input | 1 | Read target unmapped |
| rd_data | input | 32 | Read data, byte lane k from address+k |
| pc_we | output | 1 | Load PC |
| pc_out | output | 32 | New PC |
| done | output | 1 | Entry completed |
| fault | output | 1 | Entry aborted on read error |

## Verification
Status words are applied with all ones, with bit 31 clear and the rest set, and with mixed patterns. These separate the shifted field, the masked bits 30 and 31 of the shifted value, and the preserved top bit. Requests alternate between user and kernel mode, so a missing or spurious stack swap shows. Vectors range from 0 to 255 over varied bases, and read latencies run from zero to three cycles, which exposes address arithmetic, byte-lane order and response timing. Further cases are:

- a request with interrupts disabled;
- a read to the unmapped region;
- a second request held high while the first entry is still running, which checks the hold-off and the ordering of the two entries.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_FETCH = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } ent_state_e;
endpackage

// File: rtl/irq_status_xform.sv
`timescale 1ns/1ps
module irq_status_xform #(
  parameter int XLEN    = 32,
  parameter int SHIFT   = 10,
  parameter int FIELD_W = 30
) (
  input  logic [XLEN-1:0] old_st,
  output logic [XLEN-1:0] new_st
);
  localparam logic [XLEN-1:0] FIELD_MASK = {{(XLEN-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};
  localparam logic [XLEN-1:0] KEEP_MASK  = {1'b1, {(XLEN-1){1'b0}}};

  always_comb begin
    new_st = ((old_st << SHIFT) & FIELD_MASK) | (old_st & KEEP_MASK);
  end
endmodule

// File: rtl/irq_vec_path.sv
`timescale 1ns/1ps
module irq_vec_path #(
  parameter int XLEN        = 32,
  parameter int VEC_W       = 8,
  parameter int ENTRY_BYTES = 4,
  parameter int EXS_SHIFT   = 8
) (
  input  logic [XLEN-1:0]  base,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0]  rd_data,
  output logic [XLEN-1:0]  addr,
  output logic [XLEN-1:0]  exs,
  output logic [XLEN-1:0]  word
);
  localparam int NBYTES    = XLEN / 8;
  localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);

  always_comb begin
    addr = base + (XLEN'(vec) << ENT_SHIFT);
    exs  = XLEN'(vec) << EXS_SHIFT;
  end

  // little-endian assembly: lane k holds the byte at address+k
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign word[8*k +: 8] = rd_data[8*k +: 8];
  end
endmodule

// File: rtl/irq_entry_fsm.sv
`timescale 1ns/1ps
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             int_en,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             user_in,
  input  logic [XLEN-1:0]  status_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  ksp_in,
  input  logic [XLEN-1:0]  base_in,
  input  logic             rd_ack,
  input  logic             rd_err,
  input  logic [XLEN-1:0]  rd_word,
  output logic             req_ready,
  output logic             umode_clr,
  output logic             ctx_we,
  output logic             stk_we,
  output logic             rd_req,
  output logic             pc_we,
  output logic             done,
  output logic             fault,
  output logic [VEC_W-1:0] cap_vec,
  output logic [XLEN-1:0]  cap_status,
  output logic [XLEN-1:0]  cap_pc,
  output logic [XLEN-1:0]  cap_sp,
  output logic [XLEN-1:0]  cap_ksp,
  output logic [XLEN-1:0]  cap_base,
  output logic [XLEN-1:0]  fetched
);
  ent_state_e state, nxt;
  logic       cap_user;
  logic       err_q;
  logic       load_ctx;
  logic       take_rsp;

  assign load_ctx = (state == ST_IDLE) && req_valid && int_en;
  assign take_rsp = rd_req && (rd_ack || rd_err);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:           if (req_valid && int_en) nxt = ST_SAVE;
      ST_SAVE:           nxt = ST_FETCH;
      ST_FETCH, ST_WAIT: nxt = (rd_ack || rd_err) ? ST_DONE : ST_WAIT;
      ST_DONE:           nxt = ST_IDLE;
      default:           nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vec    <= '0;
      cap_user   <= 1'b0;
      cap_status <= '0;
      cap_pc     <= '0;
      cap_sp     <= '0;
      cap_ksp    <= '0;
      cap_base   <= '0;
    end else if (load_ctx) begin
      cap_vec    <= vec_in;
      cap_user   <= user_in;
      cap_status <= status_in;
      cap_pc     <= pc_in;
      cap_sp     <= sp_in;
      cap_ksp    <= ksp_in;
      cap_base   <= base_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      fetched <= '0;
    end else if (take_rsp) begin
      err_q   <= rd_err;
      if (!rd_err) fetched <= rd_word;
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    umode_clr = (state == ST_SAVE);
    ctx_we    = (state == ST_FETCH);
    stk_we    = (state == ST_FETCH) && cap_user;
    rd_req    = (state == ST_FETCH) || (state == ST_WAIT);
    done      = (state == ST_DONE) && !err_q;
    fault     = (state == ST_DONE) && err_q;
    pc_we     = done;
  end

  p_ignore_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !int_en) |=> req_ready);
  p_fault_no_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!pc_we && !done));
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (umode_clr || rd_req) |-> !req_ready);
  p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq #(
  parameter int XLEN     = 32,
  parameter int VEC_W    = 8,
  parameter int ST_SHIFT = 10,
  parameter int ST_FIELD = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  output logic             req_ready,
  input  logic             int_en,
  input  logic             user_mode,
  input  logic [XLEN-1:0]  status_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  ksp_in,
  input  logic [XLEN-1:0]  vbase_in,
  output logic             umode_clr,
  output logic             ctx_we,
  output logic [XLEN-1:0]  status_out,
  output logic [XLEN-1:0]  ret_out,
  output logic [XLEN-1:0]  exs_out,
  output logic [XLEN-1:0]  eda_out,
  output logic             stk_we,
  output logic [XLEN-1:0]  usp_out,
  output logic [XLEN-1:0]  sp_out,
  output logic             rd_req,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_ack,
  input  logic             rd_err,
  input  logic [XLEN-1:0]  rd_data,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_out,
  output logic             done,
  output logic             fault
);
  logic [1:0]       rst_sync;
  logic             rst_n_int;
  logic [VEC_W-1:0] cap_vec;
  logic [XLEN-1:0]  cap_status, cap_pc, cap_sp, cap_ksp, cap_base;
  logic [XLEN-1:0]  rd_word, fetched;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  irq_entry_fsm #(.XLEN(XLEN), .VEC_W(VEC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .int_en(int_en), .vec_in(req_vector),
    .user_in(user_mode), .status_in(status_in), .pc_in(pc_in),
    .sp_in(sp_in), .ksp_in(ksp_in), .base_in(vbase_in),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_word(rd_word),
    .req_ready(req_ready), .umode_clr(umode_clr), .ctx_we(ctx_we),
    .stk_we(stk_we), .rd_req(rd_req), .pc_we(pc_we), .done(done),
    .fault(fault), .cap_vec(cap_vec), .cap_status(cap_status),
    .cap_pc(cap_pc), .cap_sp(cap_sp), .cap_ksp(cap_ksp),
    .cap_base(cap_base), .fetched(fetched)
  );

  irq_status_xform #(.XLEN(XLEN), .SHIFT(ST_SHIFT), .FIELD_W(ST_FIELD)) u_xform (
    .old_st(cap_status), .new_st(status_out)
  );

  irq_vec_path #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vec (
    .base(cap_base), .vec(cap_vec), .rd_data(rd_data),
    .addr(rd_addr), .exs(exs_out), .word(rd_word)
  );

  assign ret_out = cap_pc;
  assign eda_out = '0;
  assign usp_out = cap_sp;
  assign sp_out  = cap_ksp;
  assign pc_out  = fetched;

  p_clear_precedes_ctx_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    ctx_we |-> $past(umode_clr));
  p_status_form_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    ctx_we |-> (status_out[XLEN-1] == cap_status[XLEN-1]
                && status_out[ST_SHIFT-1:0] == '0));
  p_stack_with_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    stk_we |-> ctx_we);
  p_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_req && !rd_ack && !rd_err) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  typedef struct packed {
    logic [31:0] st, ret, exs, usp, sp, pc, addr;
    logic        user, flt;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, int_en, user_mode;
  logic [7:0] req_vector;
  logic [31:0] status_in, pc_in, sp_in, ksp_in, vbase_in;
  logic umode_clr, ctx_we, stk_we, rd_req, rd_ack, rd_err, pc_we, done, fault;
  logic [31:0] status_out, ret_out, exs_out, eda_out, usp_out, sp_out;
  logic [31:0] rd_addr, rd_data, pc_out;

  int checks = 0, fails = 0, ev_cnt = 0, lat_g = 0;
  bit prev_clr = 0, run = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_ready(req_ready), .int_en(int_en), .user_mode(user_mode),
    .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in), .ksp_in(ksp_in),
    .vbase_in(vbase_in), .umode_clr(umode_clr), .ctx_we(ctx_we),
    .status_out(status_out), .ret_out(ret_out), .exs_out(exs_out),
    .eda_out(eda_out), .stk_we(stk_we), .usp_out(usp_out), .sp_out(sp_out),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
    .rd_data(rd_data), .pc_we(pc_we), .pc_out(pc_out), .done(done), .fault(fault)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {mbyte(a + 32'd3), mbyte(a + 32'd2), mbyte(a + 32'd1), mbyte(a)};
  endfunction

  function automatic exp_t mk(input logic [7:0] v, input logic [31:0] st, pc, sp, ksp, base, input logic usr);
    exp_t e;
    e.st   = ((st << 10) & 32'h3FFF_FFFF) | (st & 32'h8000_0000);
    e.ret  = pc;
    e.exs  = {24'd0, v} * 32'd256;
    e.usp  = sp;
    e.sp   = ksp;
    e.addr = base + {24'd0, v} * 32'd4;
    e.pc   = mword(e.addr);
    e.user = usr;
    e.flt  = (e.addr[31:28] == 4'hF);
    return e;
  endfunction

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (run) begin
        if (umode_clr || ctx_we || stk_we || rd_req || done || fault || pc_we) begin
          ev_cnt++;
          if (q.size() == 0) check(1'b0, "R1 strobe with nothing accepted", 32'd1, 32'd0);
        end
        if (ctx_we && q.size() != 0) begin
          e = q[0];
          check(prev_clr, "R3 mode clear one cycle before ctx write", {31'd0, prev_clr}, 32'd1);
          check(status_out == e.st, "R2 status", status_out, e.st);
          check(ret_out == e.ret, "R5 return address", ret_out, e.ret);
          check(exs_out == e.exs, "R5 exception status", exs_out, e.exs);
          check(eda_out == 32'd0, "R5 exception data address", eda_out, 32'd0);
          check(stk_we == e.user, "R4 stack strobe", {31'd0, stk_we}, {31'd0, e.user});
          if (e.user) begin
            check(usp_out == e.usp, "R4 user stack value", usp_out, e.usp);
            check(sp_out == e.sp, "R4 kernel sp value", sp_out, e.sp);
          end
          check(rd_req && rd_addr == e.addr, "R6 read address", rd_addr, e.addr);
        end
        if ((done || fault) && q.size() != 0) begin
          e = q.pop_front();
          check(fault == e.flt, "R7 fault flag", {31'd0, fault}, {31'd0, e.flt});
          check(done == !e.flt, "R9 done flag", {31'd0, done}, {31'd0, !e.flt});
          check(pc_we == !e.flt, "R7 pc write strobe", {31'd0, pc_we}, {31'd0, !e.flt});
          if (!e.flt) check(pc_out == e.pc, "R6 new pc", pc_out, e.pc);
        end
        prev_clr = umode_clr;
      end
    end
  end

  // memory responder
  initial begin
    logic [31:0] a;
    int l;
    rd_ack = 0; rd_err = 0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        a = rd_addr;
        l = lat_g;
        for (int i = 0; i < l; i++) begin
          @(negedge clk);
          check(rd_req && rd_addr == a, "R6 request held until response", rd_addr, a);
        end
        if (a[31:28] == 4'hF) rd_err = 1'b1;
        else begin rd_ack = 1'b1; rd_data = mword(a); end
        @(negedge clk);
        check(done || fault, "R9 end one cycle after response", {31'd0, done || fault}, 32'd1);
        rd_ack = 0; rd_err = 0; rd_data = '0;
      end
    end
  end

  task automatic set_in(input logic [7:0] v, input logic [31:0] st, pc, sp, ksp, base, input logic usr, en);
    req_vector = v; status_in = st; pc_in = pc; sp_in = sp;
    ksp_in = ksp; vbase_in = base; user_mode = usr; int_en = en;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
  endtask

  task automatic apply(input logic [7:0] v, input logic [31:0] st, pc, sp, ksp, base, input logic usr, en, input int lat);
    int ev0;
    @(negedge clk);
    set_in(v, st, pc, sp, ksp, base, usr, en);
    req_valid = 1'b1;
    lat_g = lat;
    if (en) q.push_back(mk(v, st, pc, sp, ksp, base, usr));
    ev0 = ev_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (en) check(!req_ready, "R8 ready low while busy", {31'd0, req_ready}, 32'd0);
    else    check(req_ready, "R1 ready stays high when disabled", {31'd0, req_ready}, 32'd1);
    wait_ready();
    if (!en) begin
      repeat (4) @(negedge clk);
      check(ev_cnt == ev0, "R1 no activity when disabled", ev_cnt, ev0);
    end
    @(negedge clk);
  endtask

  task automatic apply_held();
    int waited = 0;
    @(negedge clk);
    set_in(8'h21, 32'h1234_5678, 32'h0000_4000, 32'h0000_8000, 32'h0000_C000, 32'h2000_0000, 1'b1, 1'b1);
    req_valid = 1'b1;
    lat_g = 3;
    q.push_back(mk(8'h21, 32'h1234_5678, 32'h0000_4000, 32'h0000_8000, 32'h0000_C000, 32'h2000_0000, 1'b1));
    @(negedge clk);
    set_in(8'h42, 32'h8765_4321, 32'h0000_5000, 32'h0000_9000, 32'h0000_D000, 32'h3000_0000, 1'b0, 1'b1);
    q.push_back(mk(8'h42, 32'h8765_4321, 32'h0000_5000, 32'h0000_9000, 32'h0000_D000, 32'h3000_0000, 1'b0));
    while (!req_ready && waited < 60) begin
      waited++;
      @(negedge clk);
    end
    check(waited >= 5, "R8 held request not taken while busy", waited, 32'd5);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 held request taken after idle", {31'd0, req_ready}, 32'd0);
    wait_ready();
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] s = 32'h1ACE_B00C;
    rst_n = 1'b0; req_valid = 1'b0;
    set_in(8'd0, '0, '0, '0, '0, '0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1;
    check(req_ready, "R8 ready after reset", {31'd0, req_ready}, 32'd1);
    check(!(ctx_we || rd_req || done || fault || umode_clr), "R9 no strobes after reset", 32'd0, 32'd0);

    apply(8'd5, 32'h0000_0003, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 32'h1000_0000, 1'b0, 1'b1, 0);
    apply(8'hFF, 32'hFFFF_FFFF, 32'h00AB_CDE0, 32'h7000_0000, 32'h6000_0000, 32'h1000_0003, 1'b1, 1'b1, 2);
    apply(8'd0, 32'h7FFF_FFFF, 32'h0000_0002, 32'h1111_1111, 32'h2222_2222, 32'h4000_0101, 1'b0, 1'b1, 1);
    apply(8'd9, 32'hDEAD_BEEF, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 32'h5000_0000, 1'b1, 1'b0, 0);
    apply(8'd7, 32'h8000_0001, 32'h0000_0044, 32'h0000_0055, 32'h0000_0066, 32'hF000_0000, 1'b1, 1'b1, 1);
    apply(8'd3, 32'h0F0F_0F0F, 32'h0000_0088, 32'h0000_0099, 32'h0000_00AA, 32'h1234_0000, 1'b1, 1'b1, 0);
    apply_held();
    for (int i = 0; i < 8; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      apply(s[7:0], s ^ 32'h5A5A_A5A5, s + 32'd4, ~s, s >> 1,
            {4'h1, s[27:0]}, s[9], 1'b1, i % 4);
    end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9 one end pulse per accepted request", q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule